// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block sits beside a small processor core and decides when an interrupt is taken. All request lines are combined into one pending flag. An interrupt is taken only when the status word has its enable bit set and the core marks the end of an instruction. Several requests may be pending at once. The lowest-numbered line wins and is acknowledged. Its number is turned into a handler address of the form base plus number times stride. In the same cycle the core receives the PC it should push so that execution can resume.

On entry the controller records every active line in a cause register. The live enable and privilege bits move into saved fields, enable is cleared and the core enters supervisory mode. A return strobe copies the saved fields back into the live ones. Software may rewrite the status word only while in supervisory mode.

Status word encoding: bit 0 enable, bit 1 supervisory (1) or user (0), bit 2 saved enable, bit 3 saved supervisory.

Top module: `irq_entry_ctl`

## Requirements
- R1: `pending` is high in the same cycle exactly when at least one bit of `irq_req` is high.
- R2: `take` is high in the same cycle exactly when `pending`, `instr_done` and status bit 0 (enable) are all high.
- R3: `irq_ack` is zero when `take` is low. When `take` is high it is one-hot on the lowest-numbered active request line.
- R4: While `take` is high, `int_num` is the index of the winning line and `vec_pc` equals VEC_BASE + int_num * VEC_STRIDE.
- R5: While `take` is high, `save_pc` equals `cur_pc`.
- R6: On the clock edge where `take` is high, `cause` loads the full `irq_req` vector. It keeps that value on every other edge.
- R7: On the edge where `take` is high, the status word becomes: bit 0 = 0, bit 1 = 1, bit 2 = the old bit 0, bit 3 = the old bit 1.
- R8: On an edge with `rfi` high and `take` low, bits 0 and 1 take the values of bits 2 and 3. Bits 2 and 3 are unchanged.
- R9: On an edge with `st_wr` high and neither `take` nor `rfi`, the status word loads `st_wdata` if bit 1 is set. If bit 1 is clear, the status word is left unchanged.
- R10: After reset the status word is 4'b0010 (supervisory, disabled) and `cause` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Request lines, bit 0 has highest priority |
| instr_done | input | 1 | Core is at an instruction boundary |
| cur_pc | input | PCW | PC of the next instruction to run |
| rfi | input | 1 | Return-from-interrupt strobe |
| st_wr | input | 1 | Status word write strobe |
| st_wdata | input | 4 | Status word write data |
| pending | output | 1 | OR of all request lines |
| take | output | 1 | Interrupt taken this cycle |
| irq_ack | output | NSRC | One-hot acknowledge of the served line |
| int_num | output | NW | Index of the winning line |
| vec_pc | output | PCW | Handler address |
| save_pc | output | PCW | PC for the core to push |
| cause | output | NSRC | Request lines captured at entry |
| status | output | 4 | Status word |

## Verification
The bench raises a request while interrupts are disabled, and again outside an instruction boundary. A controller that ignores either gate would take the interrupt early. It also raises several lines together: a priority encoder running the wrong way would acknowledge bit 7 instead of bit 2, and the cause register would drop the losing lines. Finally it drops into user mode through a return, then attempts a status write there. A design without the privilege check would let user code clear the enable bit, and a wrong shift at entry or return would land in the wrong mode.

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl #(
  parameter int NSRC = 8,
  parameter int PCW = 32,
  parameter int NW = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter logic [PCW-1:0] VEC_BASE = 'h1000,
  parameter logic [PCW-1:0] VEC_STRIDE = 'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            instr_done,
  input  logic [PCW-1:0]  cur_pc,
  input  logic            rfi,
  input  logic            st_wr,
  input  logic [3:0]      st_wdata,
  output logic            pending,
  output logic            take,
  output logic [NSRC-1:0] irq_ack,
  output logic [NW-1:0]   int_num,
  output logic [PCW-1:0]  vec_pc,
  output logic [PCW-1:0]  save_pc,
  output logic [NSRC-1:0] cause,
  output logic [3:0]      status
);

  logic ie, sup, pie, psup;
  logic [NW-1:0] win;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (irq_req[i]) win = NW'(i);
  end

  assign pending = |irq_req;
  assign take    = pending & ie & instr_done;
  assign int_num = win;
  assign irq_ack = take ? (NSRC'(1) << win) : '0;
  assign vec_pc  = VEC_BASE + PCW'(win) * VEC_STRIDE;
  assign save_pc = cur_pc;
  assign status  = {psup, pie, sup, ie};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      sup   <= 1'b1;
      pie   <= 1'b0;
      psup  <= 1'b0;
      cause <= '0;
    end else if (take) begin
      cause <= irq_req;
      pie   <= ie;
      psup  <= sup;
      ie    <= 1'b0;
      sup   <= 1'b1;
    end else if (rfi) begin
      ie  <= pie;
      sup <= psup;
    end else if (st_wr && sup) begin
      {psup, pie, sup, ie} <= st_wdata;
    end
  end

endmodule

module irq_entry_chk #(
  parameter int NSRC = 8,
  parameter int PCW = 32,
  parameter int NW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_req,
  input logic            instr_done,
  input logic            rfi,
  input logic            st_wr,
  input logic            pending,
  input logic            take,
  input logic [NSRC-1:0] irq_ack,
  input logic [NSRC-1:0] cause,
  input logic [3:0]      status
);

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));
  assert_ack_only_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != '0) == take);
  assert_take_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (status[0] && instr_done && irq_req != '0));
  assert_entry_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status[1:0] == 2'b10 && status[2] == $past(status[0]) && status[3] == $past(status[1])));
  assert_cause_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cause == $past(irq_req));
  assert_cause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && $past(rst_n)) |=> $stable(cause));
  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi && !take) |=> status[1:0] == $past(status[3:2]));
  assert_user_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !status[1] && !take && !rfi) |=> $stable(status));

endmodule

bind irq_entry_ctl irq_entry_chk #(.NSRC(NSRC), .PCW(PCW), .NW(NW)) chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
  .rfi(rfi), .st_wr(st_wr), .pending(pending), .take(take),
  .irq_ack(irq_ack), .cause(cause), .status(status)
);

// File: tb/sim_irq_entry_ctl.sv
module sim_irq_entry_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] irq_req = 0;
  logic instr_done = 0;
  logic [31:0] cur_pc = 0;
  logic rfi = 0, st_wr = 0;
  logic [3:0] st_wdata = 0;
  logic pending, take;
  logic [7:0] irq_ack, cause;
  logic [2:0] int_num;
  logic [31:0] vec_pc, save_pc;
  logic [3:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_ctl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
    .cur_pc(cur_pc), .rfi(rfi), .st_wr(st_wr), .st_wdata(st_wdata),
    .pending(pending), .take(take), .irq_ack(irq_ack), .int_num(int_num),
    .vec_pc(vec_pc), .save_pc(save_pc), .cause(cause), .status(status)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive_idle();
    @(negedge clk);
    irq_req = 0; instr_done = 0; rfi = 0; st_wr = 0; st_wdata = 0;
    #1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    @(negedge clk); rst_n = 1; #1;
    chk("R10 status", 32'(status), 32'h2);
    chk("R10 cause", 32'(cause), 0);
    chk("R1 pending idle", 32'(pending), 0);
  endtask

  task automatic t_gating();
    @(negedge clk); irq_req = 8'h20; instr_done = 1; cur_pc = 32'h400; #1;
    chk("R1 pending", 32'(pending), 1);
    chk("R2 no take when disabled", 32'(take), 0);
    chk("R3 no ack", 32'(irq_ack), 0);
    step();
    chk("R6 cause untouched", 32'(cause), 0);
    drive_idle(); st_wr = 1; st_wdata = 4'b0011; step();
    chk("R9 supervisory write", 32'(status), 32'h3);
    drive_idle(); irq_req = 8'h20; instr_done = 0; #1;
    chk("R2 no take mid-instruction", 32'(take), 0);
    @(negedge clk); instr_done = 1; #1;
    chk("R2 take", 32'(take), 1);
    chk("R3 ack", 32'(irq_ack), 32'h20);
    chk("R4 num", 32'(int_num), 5);
    chk("R4 vec", vec_pc, 32'h1050);
    chk("R5 save pc", save_pc, 32'h400);
    step();
    chk("R7 entry status", 32'(status), 32'hE);
    chk("R6 cause", 32'(cause), 32'h20);
    drive_idle(); rfi = 1; step();
    chk("R8 return", 32'(status), 32'hF);
  endtask

  task automatic t_priority();
    drive_idle(); irq_req = 8'h94; instr_done = 1; cur_pc = 32'h88; #1;
    chk("R3 lowest wins", 32'(irq_ack), 32'h04);
    chk("R4 num prio", 32'(int_num), 2);
    chk("R4 vec prio", vec_pc, 32'h1020);
    chk("R5 save pc prio", save_pc, 32'h88);
    step();
    chk("R6 multi cause", 32'(cause), 32'h94);
    chk("R7 status prio", 32'(status), 32'hE);
    drive_idle(); irq_req = 8'h01; instr_done = 1; #1;
    chk("R2 disabled in handler", 32'(take), 0);
    step();
    chk("R6 cause held", 32'(cause), 32'h94);
    drive_idle(); rfi = 1; step();
    chk("R8 return prio", 32'(status), 32'hF);
  endtask

  task automatic t_user();
    drive_idle(); st_wr = 1; st_wdata = 4'b0110; step();
    chk("R9 write saved fields", 32'(status), 32'h6);
    drive_idle(); rfi = 1; step();
    chk("R8 into user", 32'(status), 32'h5);
    drive_idle(); st_wr = 1; st_wdata = 4'b0000; step();
    chk("R9 user write ignored", 32'(status), 32'h5);
    drive_idle(); irq_req = 8'h80; instr_done = 1; cur_pc = 32'hABC; #1;
    chk("R2 take from user", 32'(take), 1);
    chk("R4 vec top", vec_pc, 32'h1070);
    step();
    chk("R7 entry from user", 32'(status), 32'h6);
    drive_idle(); rfi = 1; step();
    chk("R8 back to user", 32'(status), 32'h5);
    drive_idle();
  endtask

  initial begin
    t_reset();
    t_gating();
    t_priority();
    t_user();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule